// File: doc/BRIEF.md
# Device-Clocked Host Serial Port

This block links a network controller to a host microcontroller over a three-wire synchronous serial link. The controller supplies the serial clock, and the host is the slave. The host asks for a transfer by raising one of two request lines. A rising edge on `statReq` asks for a status/control exchange, and a rising edge on `rdyReq` asks for a data exchange. The port then raises `xferActive` and waits out a lead time, which is longer for data. It clocks eight bits out and eight bits in at the same time, most significant bit first. It holds `xferActive` for a short lag, and then keeps a recovery gap before it starts another transfer.

The serial clock is built from the system clock. One half-period of SCK lasts `divSel+1` system clock cycles. Lead, lag and recovery times are counted in these half-periods (ticks). The core loads the byte to send at the start of the lead time: `txStatus` or `txData`, chosen by the kind of transfer. The core gets the received byte back with a one-cycle valid strobe and a flag that gives the kind of transfer. SCK and SOUT are driven only while `xferActive` is high, so other devices can share the lines between transfers. The enable outputs control the pad drivers.

Top module: `host_serial_port`

## Requirements
- R1: Each transfer shifts exactly 8 bits. SOUT presents bit 7 of the loaded byte first and then bits 6 down to 0. SIN is assembled into the received byte with the first bit sampled landing in bit 7.
- R2: SCK starts low inside a transfer. Each high phase and each low phase between SCK edges lasts exactly `divSel+1` system clock cycles. SIN is sampled on the SCK rising edge, and SOUT changes on the SCK falling edge.
- R3: A rising edge on `statReq` causes one exchange that sends `txStatus` and reports `rxIsStatus`=1. A rising edge on `rdyReq` causes one exchange that sends `txData` and reports `rxIsStatus`=0.
- R4: The first SCK rising edge comes `(LEAD+1)*(divSel+1)` cycles after `xferActive` rises. LEAD is `STAT_LEAD` (1) for a status transfer and `DATA_LEAD` (2) for a data transfer. `xferActive` falls `LAG*(divSel+1)` cycles after the last SCK falling edge (LAG=1).
- R5: `sckEn` and `soutEn` are high exactly when `xferActive` is high. SCK is low whenever `xferActive` is low.
- R6: After `xferActive` falls, the next transfer does not begin until `RECOVER*(divSel+1)+1` cycles have passed (RECOVER=3). When a request is already pending, the next transfer begins at exactly that point.
- R7: Requests are edge-triggered. A request edge that arrives during a transfer or during recovery is held and served afterwards. A `rdyReq` held high past the last SCK edge starts no second transfer.
- R8: When status and data requests are pending together, the status exchange is served first.
- R9: `rxValid` pulses for one cycle after the eighth bit is taken in, and it carries `rxByte` and `rxIsStatus`. It pulses exactly once per transfer.
- R10: After reset, `xferActive`, `sckEn`, `soutEn`, `sckOut` and `rxValid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divSel | input | DIV_W | SCK half-period minus one, in system clock cycles |
| statReq | input | 1 | Host request for a status/control exchange (edge) |
| rdyReq | input | 1 | Host request for a data exchange (edge) |
| sin | input | 1 | Serial data from the host |
| txStatus | input | 8 | Status/control byte to send |
| txData | input | 8 | Data byte to send |
| sckOut | output | 1 | Serial clock level |
| sckEn | output | 1 | Serial clock driver enable |
| soutOut | output | 1 | Serial data to the host |
| soutEn | output | 1 | Serial data driver enable |
| xferActive | output | 1 | Transfer-active strobe |
| rxByte | output | 8 | Received byte |
| rxValid | output | 1 | One-cycle strobe for the received byte |
| rxIsStatus | output | 1 | Received byte belongs to a status exchange |

## Verification
The bench runs single status and data exchanges at three clock dividers, including the divide-by-one case. This separates a lead time that is right for each request kind from one shared by both, and a true half-period count from an off-by-one count. Mirror and alternating bit patterns show whether bit order and the sampling edge are right. Simultaneous requests test priority. A status edge raised during a data transfer shows that requests are latched and that the recovery gap is exact. A data request held high through a whole transfer shows whether the port detects edges or triggers on levels.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_LAG, ST_RECOV} hspState_t;

  typedef struct packed {
    logic load;        // capture transmit byte, lead time begins
    logic kindStatus;  // kind of the transfer being loaded
    logic sample;      // SCK rising: take SIN
    logic shift;       // SCK falling: advance registers
    logic done;        // final falling edge: eighth bit complete
  } hspStrobes_t;
endpackage

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
  import hsp_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int STAT_LEAD = 1,
  parameter int DATA_LEAD = 2,
  parameter int LAG       = 1,
  parameter int RECOVER   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic             statReq,
  input  logic             rdyReq,
  output hspStrobes_t      strb,
  output logic             sckOut,
  output logic             xferActive
);
  localparam int LEAD_MAX = (DATA_LEAD > STAT_LEAD) ? DATA_LEAD : STAT_LEAD;
  localparam int GAP_MAX  = (LAG > RECOVER) ? LAG : RECOVER;
  localparam int T_MAX    = (LEAD_MAX > GAP_MAX) ? LEAD_MAX : GAP_MAX;
  localparam int CNT_W    = $clog2(T_MAX + 1);

  hspState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitCnt;
  logic             statPrev, rdyPrev, statPend, rdyPend;
  logic             tick, takeStat, takeRdy;

  assign tick       = (divCnt == divSel);
  assign takeStat   = (state == ST_IDLE) && statPend;
  assign takeRdy    = (state == ST_IDLE) && !statPend && rdyPend;
  assign xferActive = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_LAG);

  always_comb begin
    strb            = '0;
    strb.load       = takeStat || takeRdy;
    strb.kindStatus = takeStat;
    strb.sample     = (state == ST_SHIFT) && tick && !sckOut;
    strb.shift      = (state == ST_SHIFT) && tick && sckOut;
    strb.done       = strb.shift && (bitCnt == 3'd7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      tickCnt  <= '0;
      bitCnt   <= '0;
      sckOut   <= 1'b0;
      statPrev <= 1'b0;
      rdyPrev  <= 1'b0;
      statPend <= 1'b0;
      rdyPend  <= 1'b0;
    end else begin
      statPrev <= statReq;
      rdyPrev  <= rdyReq;
      statPend <= (statPend && !takeStat) || (statReq && !statPrev);
      rdyPend  <= (rdyPend && !takeRdy) || (rdyReq && !rdyPrev);
      if (state == ST_IDLE) divCnt <= '0;
      else                  divCnt <= tick ? '0 : divCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          sckOut <= 1'b0;
          if (takeStat || takeRdy) begin
            state   <= ST_LEAD;
            tickCnt <= takeStat ? CNT_W'(STAT_LEAD - 1) : CNT_W'(DATA_LEAD - 1);
          end
        end
        ST_LEAD: if (tick) begin
          if (tickCnt == '0) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end else tickCnt <= tickCnt - 1'b1;
        end
        ST_SHIFT: if (tick) begin
          sckOut <= !sckOut;
          if (sckOut) begin
            if (bitCnt == 3'd7) begin
              state   <= ST_LAG;
              tickCnt <= CNT_W'(LAG - 1);
            end else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_LAG: if (tick) begin
          if (tickCnt == '0) begin
            state   <= ST_RECOV;
            tickCnt <= CNT_W'(RECOVER - 1);
          end else tickCnt <= tickCnt - 1'b1;
        end
        ST_RECOV: if (tick) begin
          if (tickCnt == '0) state <= ST_IDLE;
          else tickCnt <= tickCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(sckOut)); // R2
  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> !sckOut); // R5
  AST_RECOV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOV) |=> (state == ST_RECOV || state == ST_IDLE)); // R6
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !xferActive); // R7
endmodule

// File: rtl/hsp_datapath.sv
module hsp_datapath
  import hsp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hspStrobes_t strb,
  input  logic [7:0]  txStatus,
  input  logic [7:0]  txData,
  input  logic        sin,
  output logic        soutBit,
  output logic [7:0]  rxByte,
  output logic        rxValid,
  output logic        rxIsStatus
);
  logic [7:0] txShift;
  logic [7:0] rxShift;
  logic       sinHold;
  logic       kindReg;

  assign soutBit = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '0;
      rxShift    <= '0;
      sinHold    <= 1'b0;
      kindReg    <= 1'b0;
      rxByte     <= '0;
      rxValid    <= 1'b0;
      rxIsStatus <= 1'b0;
    end else begin
      rxValid <= strb.done;
      if (strb.load) begin
        txShift <= strb.kindStatus ? txStatus : txData;
        kindReg <= strb.kindStatus;
      end else if (strb.shift) begin
        txShift <= {txShift[6:0], 1'b0};
      end
      if (strb.sample) sinHold <= sin;
      if (strb.shift)  rxShift <= {rxShift[6:0], sinHold};
      if (strb.done) begin
        rxByte     <= {rxShift[6:0], sinHold};
        rxIsStatus <= kindReg;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(txShift)); // R1
endmodule

// File: rtl/host_serial_port.sv
module host_serial_port
  import hsp_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int STAT_LEAD = 1,
  parameter int DATA_LEAD = 2,
  parameter int LAG       = 1,
  parameter int RECOVER   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic             statReq,
  input  logic             rdyReq,
  input  logic             sin,
  input  logic [7:0]       txStatus,
  input  logic [7:0]       txData,
  output logic             sckOut,
  output logic             sckEn,
  output logic             soutOut,
  output logic             soutEn,
  output logic             xferActive,
  output logic [7:0]       rxByte,
  output logic             rxValid,
  output logic             rxIsStatus
);
  hspStrobes_t strb;
  logic        soutBit;

  hsp_ctrl #(
    .DIV_W(DIV_W), .STAT_LEAD(STAT_LEAD), .DATA_LEAD(DATA_LEAD),
    .LAG(LAG), .RECOVER(RECOVER)
  ) ctrl (
    .clk(clk), .rstN(rstN), .divSel(divSel), .statReq(statReq), .rdyReq(rdyReq),
    .strb(strb), .sckOut(sckOut), .xferActive(xferActive)
  );

  hsp_datapath dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txStatus(txStatus), .txData(txData),
    .sin(sin), .soutBit(soutBit), .rxByte(rxByte), .rxValid(rxValid),
    .rxIsStatus(rxIsStatus)
  );

  assign sckEn   = xferActive;
  assign soutEn  = xferActive;
  assign soutOut = soutBit;
endmodule

// File: tb/host_serial_port_test.sv
module host_serial_port_test;
  localparam int STAT_LEAD = 1;
  localparam int DATA_LEAD = 2;
  localparam int LAG       = 1;
  localparam int RECOVER   = 3;

  typedef struct {
    bit       isStat;
    bit [7:0] tx;
    bit [7:0] rx;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] divSel = 4'd1;
  logic       statReq = 1'b0, rdyReq = 1'b0, sin = 1'b0;
  logic [7:0] txStatus = '0, txData = '0;
  logic       sckOut, sckEn, soutOut, soutEn, xferActive, rxValid, rxIsStatus;
  logic [7:0] rxByte;

  int errors = 0, checks = 0;
  expItem_t expQ[$];
  bit tightNext = 0;

  always #2.5 clk = ~clk;

  host_serial_port #(.DIV_W(4), .STAT_LEAD(STAT_LEAD), .DATA_LEAD(DATA_LEAD),
                     .LAG(LAG), .RECOVER(RECOVER)) uut (
    .clk(clk), .rstN(rstN), .divSel(divSel), .statReq(statReq), .rdyReq(rdyReq),
    .sin(sin), .txStatus(txStatus), .txData(txData), .sckOut(sckOut), .sckEn(sckEn),
    .soutOut(soutOut), .soutEn(soutEn), .xferActive(xferActive), .rxByte(rxByte),
    .rxValid(rxValid), .rxIsStatus(rxIsStatus)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor / scoreboard
  int cyc = 0, actRise = 0, lastRise = 0, lastFall = 0, lastActFall = -1, bitIdx = 0;
  logic prevAct = 0, prevSck = 0, prevValid = 0;
  expItem_t cur;
  always @(negedge clk) begin
    if (rstN) begin
      automatic int half = int'(divSel) + 1;
      cyc++;
      if (sckEn !== xferActive || soutEn !== xferActive)
        check(0, "R5 enables follow xferActive", int'(sckEn), int'(xferActive));
      if (!xferActive && sckOut)
        check(0, "R5 sck low when inactive", 1, 0);
      if (xferActive && !prevAct) begin
        if (expQ.size() == 0) begin
          check(0, "R7 unexpected transfer", 1, 0);
          cur = '{0, 8'h00, 8'h00};
        end else cur = expQ[0];
        actRise = cyc; bitIdx = 0;
        sin = cur.rx[7];
        if (lastActFall >= 0) begin
          if (tightNext)
            check(cyc - lastActFall == RECOVER*half + 1, "R6 exact recovery gap",
                  cyc - lastActFall, RECOVER*half + 1);
          else
            check(cyc - lastActFall >= RECOVER*half + 1, "R6 minimum recovery gap",
                  cyc - lastActFall, RECOVER*half + 1);
        end
        tightNext = 0;
      end
      if (xferActive && sckOut && !prevSck) begin
        if (bitIdx == 0) begin
          automatic int lead = cur.isStat ? STAT_LEAD : DATA_LEAD;
          check(cyc - actRise == (lead+1)*half, "R4 lead time",
                cyc - actRise, (lead+1)*half);
        end else
          check(cyc - lastFall == half, "R2 low phase", cyc - lastFall, half);
        if (bitIdx < 8)
          check(soutOut == cur.tx[7-bitIdx], "R1 sout bit", int'(soutOut),
                int'(cur.tx[7-bitIdx]));
        lastRise = cyc;
      end
      if (xferActive && !sckOut && prevSck) begin
        check(cyc - lastRise == half, "R2 high phase", cyc - lastRise, half);
        bitIdx++;
        if (bitIdx < 8) sin = cur.rx[7-bitIdx];
        lastFall = cyc;
      end
      if (!xferActive && prevAct) begin
        check(cyc - lastFall == LAG*half, "R4 lag time", cyc - lastFall, LAG*half);
        check(bitIdx == 8, "R1 eight bits per transfer", bitIdx, 8);
        lastActFall = cyc;
      end
      if (rxValid) begin
        check(!prevValid, "R9 single-cycle strobe", int'(prevValid), 0);
        if (expQ.size() == 0) check(0, "R9 strobe without transfer", 1, 0);
        else begin
          check(rxByte == cur.rx, "R1 received byte", int'(rxByte), int'(cur.rx));
          check(rxIsStatus == cur.isStat, "R3 transfer kind", int'(rxIsStatus),
                int'(cur.isStat));
          check(cur.isStat == expQ[0].isStat, "R8 service order", int'(cur.isStat),
                int'(expQ[0].isStat));
          void'(expQ.pop_front());
        end
      end
      prevAct = xferActive; prevSck = sckOut; prevValid = rxValid;
    end
  end

  task automatic request(bit isStat, bit [7:0] tx, bit [7:0] rx, int hold);
    expQ.push_back('{isStat, tx, rx});
    @(negedge clk);
    if (isStat) begin txStatus = tx; statReq = 1'b1; end
    else        begin txData = tx;   rdyReq = 1'b1; end
    repeat (hold) @(negedge clk);
    statReq = 1'b0; rdyReq = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat ((RECOVER + 2) * (int'(divSel) + 1) + 4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check(xferActive == 0 && sckEn == 0 && soutEn == 0, "R10 inactive after reset",
          int'(xferActive), 0);
    check(rxValid == 0 && sckOut == 0, "R10 strobes low after reset", int'(rxValid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    foreach (divSel[i]) ; // no-op keeps loop vars local
    for (int d = 0; d < 3; d++) begin
      divSel = (d == 2) ? 4'd3 : 4'(d);
      request(1, 8'hA5, 8'h3C, 2); drain();  // R3 status
      request(0, 8'h81, 8'h7E, 2); drain();  // R3 data
      request(0, 8'h55, 8'hAA, 1); drain();  // R1 alternating
    end

    divSel = 4'd1;
    // R8: both pending together, status first
    expQ.push_back('{1, 8'hC3, 8'h0F});
    expQ.push_back('{0, 8'h18, 8'hF0});
    @(negedge clk);
    txStatus = 8'hC3; txData = 8'h18;
    statReq = 1; rdyReq = 1;
    @(negedge clk); statReq = 0; rdyReq = 0;
    wait (expQ.size() == 1); tightNext = 1;
    drain();

    // R7: status edge during a data transfer is held, served after exact gap
    request(0, 8'h96, 8'h69, 1);
    wait (xferActive == 1);
    repeat (5) @(negedge clk);
    tightNext = 1;
    request(1, 8'hE7, 8'h24, 1);
    drain();

    // R7: long rdy held beyond the transfer starts only one exchange
    request(0, 8'h01, 8'h80, 1);
    rdyReq = 1;
    wait (expQ.size() == 0);
    repeat (60) @(negedge clk);
    check(xferActive == 0, "R7 held rdy no retrigger", int'(xferActive), 0);
    rdyReq = 0;
    repeat (20) @(negedge clk);
    check(expQ.size() == 0 && xferActive == 0, "R7 queue drained", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule